// File: doc/BRIEF.md
# Fixed-Latency Read Memory with Decoupled Response Stream

This block places a synchronous read memory with a fixed pipeline latency behind two valid/ready streams. A consumer sends read addresses on the request stream. The matching data words come back on the response stream in the order the addresses were accepted. The response side may hold its ready input low for any number of cycles. Data that leaves the memory pipeline during a stall is parked in an internal response buffer, so no word is ever dropped.

Admission is controlled by a count of outstanding reads. The count covers every read that has been accepted but not yet taken by the consumer, whether it is still in the memory pipeline or already waiting in the buffer. The count rises on each accepted request and falls on each taken response. Requests are refused once the count reaches the buffer depth, so every word that is still in flight is sure to find a free slot. The buffer is at least as deep as the memory latency. When the buffer is empty, a word leaving the pipeline goes straight to the response port without a buffering cycle. A consumer that never stalls therefore keeps one read per cycle flowing without a break.

Back-pressure rules: a request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_valid` is high and no transfer happens, `rsp_valid` and `rsp_data` stay unchanged. `rsp_valid` and `rsp_data` depend only on internal registers. `req_ready` depends on registers and, combinationally, on a response transfer in the same cycle.

Top module: `lmw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The word returned for address `a` is `(a * 40503 + 4660)` modulo 2^DATA_W. The memory holds this pattern from reset onward.
- R3: With the block idle, a request accepted on edge k makes `rsp_valid` rise only after edge k+LATENCY-1, carrying that request's word.
- R4: Responses come out in request order, each exactly once, under any pattern of consumer stalls.
- R5: While `rsp_valid` is 1 and `rsp_ready` is 0, the next cycle shows `rsp_valid` at 1 and the same `rsp_data`.
- R6: With no responses taken, exactly BUF_DEPTH requests are accepted. After that, `req_ready` stays 0 and the buffer never overflows.
- R7: At the limit, a response taken in a cycle raises `req_ready` in that same cycle. The outstanding count is unchanged by a request and a take in one cycle, so `req_ready` is 0 again in the next cycle if nothing is taken then.
- R8: With `rsp_ready` held at 1, `req_ready` never drops, so one read per cycle is sustained.
- R9: `rsp_valid` is 0 whenever no accepted request remains untaken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read address offered |
| req_ready | output | 1 | Block can accept a read address |
| req_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Response word available |
| rsp_ready | input | 1 | Consumer takes the response word |
| rsp_data | output | DATA_W | Oldest untaken response word |

## Verification
A vector table pairs addresses with fixed stall lengths, which exercises buffer storage and shows whether a held word stays stable during a stall. A single isolated read measures the exact latency. A run with the consumer blocked shows whether admission stops at the buffer depth, and a single take at that limit shows the same-cycle reopening. A stream with no stalls separates a bypassed buffer from one that adds a cycle or throttles requests. A long run with random stalls catches reordering, loss or duplication when bypass and buffered paths alternate.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  // Pattern stored in the read memory at reset: word for address a.
  localparam int unsigned FILL_MUL = 40503;
  localparam int unsigned FILL_ADD = 4660;

  function automatic int unsigned lmw_fill(input int unsigned a);
    return a * FILL_MUL + FILL_ADD;
  endfunction
endpackage

// File: rtl/lmw_lat_ram.sv
module lmw_lat_ram
  import lmw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] cells  [WORDS];
  logic [DATA_W-1:0] pipe_d [LATENCY];
  logic [LATENCY-1:0] pipe_v;

  // Contents are loaded with the fill pattern during reset; no write path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= DATA_W'(lmw_fill(i));
    end
  end

  // Valid pipeline with reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_v <= '0;
    end else begin
      pipe_v[0] <= rd_en;
      for (int s = 1; s < LATENCY; s++) pipe_v[s] <= pipe_v[s-1];
    end
  end

  // Data pipeline without reset.
  always_ff @(posedge clk) begin
    pipe_d[0] <= cells[rd_addr];
    for (int s = 1; s < LATENCY; s++) pipe_d[s] <= pipe_d[s-1];
  end

  assign out_valid = pipe_v[LATENCY-1];
  assign out_data  = pipe_d[LATENCY-1];
endmodule

// File: rtl/lmw_credit.sv
module lmw_credit #(
  parameter int LIMIT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inc,
  input  logic                         dec,
  output logic [$clog2(LIMIT+1)-1:0]   cnt,
  output logic                         at_limit
);
  localparam int CW = $clog2(LIMIT + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      cnt <= cnt + CW'(1);
    end else if (dec && !inc) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign at_limit = (cnt == CW'(LIMIT));

  a_r6_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt != '0);
  a_r7_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> cnt == $past(cnt));
endmodule

// File: rtl/lmw_rsp_buf.sv
module lmw_rsp_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [OW-1:0] occ;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      if (wr_en && !rd_en)      occ <= occ + OW'(1);
      else if (rd_en && !wr_en) occ <= occ - OW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slots[wp] <= wr_data;
  end

  assign head  = slots[rp];
  assign empty = (occ == '0);
  assign full  = (occ == OW'(DEPTH));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  a_r4_buf_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
endmodule

// File: rtl/lmw_top.sv
module lmw_top #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LATENCY   = 3,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  initial begin
    a_depth_covers_latency: assert (BUF_DEPTH >= LATENCY && LATENCY >= 1);
  end

  logic              req_fire, rsp_fire;
  logic              ram_valid;
  logic [DATA_W-1:0] ram_data;
  logic              buf_wr, buf_rd, buf_empty, buf_full;
  logic [DATA_W-1:0] buf_head;
  logic [CW-1:0]     outstanding;
  logic              at_limit;

  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  // A take in this cycle frees one credit at once.
  assign req_ready = !at_limit || rsp_fire;

  lmw_lat_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATENCY(LATENCY)) u_ram (
    .clk(clk), .rst_n(rst_n), .rd_en(req_fire), .rd_addr(req_addr),
    .out_valid(ram_valid), .out_data(ram_data)
  );

  lmw_credit #(.LIMIT(BUF_DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n), .inc(req_fire), .dec(rsp_fire),
    .cnt(outstanding), .at_limit(at_limit)
  );

  // Buffer bypass: a word emerging into an empty buffer is presented directly.
  assign buf_wr = ram_valid && !(buf_empty && rsp_fire);
  assign buf_rd = rsp_fire && !buf_empty;

  lmw_rsp_buf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_data(ram_data),
    .rd_en(buf_rd), .head(buf_head), .empty(buf_empty), .full(buf_full)
  );

  assign rsp_valid = !buf_empty || ram_valid;
  assign rsp_data  = buf_empty ? ram_data : buf_head;

  a_r9_valid_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> outstanding != '0);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> at_limit);
endmodule

// File: tb/sim_lmw_top.sv
module sim_lmw_top;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int LAT = 3;
  localparam int DEP = 4;
  localparam int NV  = 16;

  // Vector table: read address and consumer stall cycles before taking it.
  localparam logic [AW-1:0] VEC_ADDR [NV] = '{8'h00, 8'hFF, 8'h01, 8'h80,
    8'h7F, 8'h10, 8'h10, 8'h3C, 8'hC3, 8'h55, 8'hAA, 8'h02, 8'hFE, 8'h40,
    8'h99, 8'h0F};
  localparam int VEC_STALL [NV] = '{0, 3, 0, 1, 5, 0, 2, 0, 6, 1, 0, 4, 0,
    2, 7, 0};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] exp_q [1024];
  int wr_i = 0, rd_i = 0;

  always #5 clk = ~clk;

  lmw_top #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT), .BUF_DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    int unsigned v = 32'(a) * 40503 + 4660;
    return v[DW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: table vectors, 1: random addresses and stalls, 2: no stalls
  task automatic stream(input int n, input int mode);
    int sent = 0, got = 0, stall = 0;
    bit hold = 0, take;
    logic [DW-1:0] held = '0;
    logic [AW-1:0] pend = (mode == 0) ? VEC_ADDR[0] : AW'($urandom);
    while (got < n) begin
      @(negedge clk);
      if (hold) check(rsp_valid && rsp_data == held, "R5 hold", rsp_data, held);
      if (sent == got) check(!rsp_valid, "R9 idle valid", rsp_valid, 0);
      rsp_ready = 0;
      hold = 0;
      if (rsp_valid) begin
        if (mode == 2) take = 1;
        else if (mode == 0) take = (stall >= VEC_STALL[got % NV]);
        else take = ($urandom % 3 != 0);
        if (take) begin
          check(rsp_data == exp_q[rd_i], "R4 R2 order/data", rsp_data, exp_q[rd_i]);
          rd_i++; got++; stall = 0;
          rsp_ready = 1;
        end else begin
          hold = 1; held = rsp_data; stall++;
        end
      end
      #1;
      req_valid = 0;
      if (sent < n) begin
        req_valid = 1;
        req_addr = pend;
        if (mode == 2) check(req_ready, "R8 no throttle", req_ready, 1);
        if (req_ready) begin
          exp_q[wr_i] = model(pend);
          wr_i++; sent++;
          pend = (mode == 0) ? VEC_ADDR[sent % NV] : AW'($urandom);
        end
      end
    end
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1 req_ready", req_ready, 1);
    check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);

    // R3 latency of one isolated read
    req_valid = 1; req_addr = 8'h5A;
    exp_q[wr_i] = model(8'h5A); wr_i++;
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (i < LAT) check(!rsp_valid, "R3 early valid", rsp_valid, 0);
      else check(rsp_valid && rsp_data == exp_q[rd_i], "R3 R2 on time",
                 {15'd0, rsp_valid, rsp_data}, {16'd1, exp_q[rd_i]});
    end
    rsp_ready = 1; rd_i++;
    @(negedge clk);
    rsp_ready = 0;

    // R6 admission limit with consumer blocked
    acc = 0;
    for (int i = 0; i < DEP + 3; i++) begin
      @(negedge clk);
      req_valid = 1; req_addr = AW'(i * 7 + 3);
      #1;
      if (req_ready) begin
        exp_q[wr_i] = model(req_addr); wr_i++; acc++;
      end
    end
    @(negedge clk);
    req_valid = 0;
    check(acc == DEP, "R6 accepted count", acc, DEP);
    repeat (LAT + 2) @(negedge clk);
    check(!req_ready, "R6 blocked at limit", req_ready, 0);

    // R7 same-cycle reopening, then count unchanged
    check(rsp_valid && rsp_data == exp_q[rd_i], "R7 head data", rsp_data, exp_q[rd_i]);
    rsp_ready = 1; rd_i++;
    req_valid = 1; req_addr = 8'hE1;
    #1;
    check(req_ready, "R7 reopen same cycle", req_ready, 1);
    exp_q[wr_i] = model(8'hE1); wr_i++;
    @(negedge clk);
    rsp_ready = 0; req_valid = 0;
    #1;
    check(!req_ready, "R7 count unchanged", req_ready, 0);
    stream(0, 0);
    // drain the DEP words still outstanding, in order
    for (int k = 0; k < DEP; k++) begin
      @(negedge clk);
      rsp_ready = 0;
      check(rsp_valid && rsp_data == exp_q[rd_i], "R4 drain order", rsp_data, exp_q[rd_i]);
      rsp_ready = 1; rd_i++;
    end
    @(negedge clk);
    rsp_ready = 0;
    check(!rsp_valid, "R9 empty after drain", rsp_valid, 0);

    stream(NV, 0);   // table with fixed stalls: R2 R4 R5
    stream(32, 2);   // no stalls: R8
    stream(300, 1);  // random stalls: R4 R5 R9
    repeat (LAT + 2) @(negedge clk);
    check(!rsp_valid && req_ready, "R9 idle at end", {rsp_valid, req_ready}, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule